// File: doc/BRIEF.md
# Inverted Bit-Field Insert Unit

This unit carries out one 16-bit datapath operation. It takes the low-order field of a source word, inverts every bit of that field, and merges the inverted field into a copy of the destination word at a chosen bit position. A single control word holds both the field length and the starting position, one nibble each. Bits of the destination outside the field pass through unchanged. Field bits that would land above bit 15 are dropped and do not wrap around to bit 0.

Each operation also produces the four condition flags. Negative copies the top bit of the result. Zero marks a result of all zeros. Overflow is always cleared. Carry is passed through from the incoming flag. The result and flags are registered, so one operation is accepted every cycle and its result appears one clock later. A source of all zeros turns the operation into a "set this bit range" primitive.

Top module: `bitfield_insert_inv`

## Requirements
- R1: The field length is ctl_word[7:4] plus one, giving 1 to 16 bits. The starting bit is ctl_word[3:0].
- R2: Result bits [len-1+pos : pos] equal the inverted source bits [len-1 : 0]. Source bits above the field have no effect on the result.
- R3: Result bits outside the field equal the corresponding bits of dst_word.
- R4: When pos + len - 1 exceeds 15, the field bits that would fall above bit 15 are discarded. They do not wrap, and the low bits below pos keep the dst_word value.
- R5: flag_n equals bit 15 of the result. flag_z is 1 exactly when the 16-bit result is 0x0000.
- R6: flag_v is 0 after every operation. flag_c equals the c_in value presented with that operation.
- R7: res_valid is 1 in the cycle after in_valid is sampled high, and 0 otherwise. Result and flags update only on accepted operations and hold their values in between.
- R8: ctl_word[15:8] has no effect on the result or the flags.
- R9: A synchronous active-high reset clears the result, all flags and res_valid to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_word | input | 16 | Source operand; its low field is inverted and inserted |
| ctl_word | input | 16 | Control: [7:4] length minus one, [3:0] start bit |
| dst_word | input | 16 | Current destination value |
| c_in | input | 1 | Incoming carry flag |
| result | output | 16 | Merged result |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag, always cleared |
| flag_c | output | 1 | Carry flag, passed through |
| res_valid | output | 1 | Result valid, one cycle after in_valid |

## Verification
The hardest case to reach from the ports is a field that is clipped at bit 15 and also produces a zero result. Reaching it needs a large offset, a wide length, a source whose low bits are all ones, and a destination that is zero below the offset. Random operands almost never line up this way, so the stimulus adds directed vectors for these conditions. The random phase also sweeps every length and offset pair with random source, destination and upper control bits, so that clipping and the ignored control bits are exercised broadly.

// File: rtl/bitfield_insert_inv.sv
module bitfield_insert_inv #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] src_word,
  input  logic [W-1:0] ctl_word,
  input  logic [W-1:0] dst_word,
  input  logic         c_in,
  output logic [W-1:0] result,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_v,
  output logic         flag_c,
  output logic         res_valid
);
  localparam int FW = $clog2(W);

  logic [FW-1:0] len_m1, pos;
  logic [W-1:0]  field_mask, ins_mask, ins_bits, merged;

  assign len_m1 = ctl_word[2*FW-1:FW];
  assign pos    = ctl_word[FW-1:0];

  always_comb begin
    for (int i = 0; i < W; i++)
      field_mask[i] = (i <= int'(len_m1));
  end

  assign ins_mask = field_mask << pos;
  assign ins_bits = (~src_word & field_mask) << pos;
  assign merged   = (dst_word & ~ins_mask) | ins_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      result    <= '0;
      flag_n    <= 1'b0;
      flag_z    <= 1'b0;
      flag_v    <= 1'b0;
      flag_c    <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        result <= merged;
        flag_n <= merged[W-1];
        flag_z <= (merged == '0);
        flag_v <= 1'b0;
        flag_c <= c_in;
      end
    end
  end

  // R5
  n_tracks_msb_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_n == result[W-1]));
  // R5
  z_tracks_zero_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (flag_z == (result == '0)));
  // R6
  v_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !flag_v);
  // R6
  c_pass_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (flag_c == $past(c_in)));
  // R7
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid);
  // R7
  hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && !res_valid));
  // R3
  outside_kept_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ((result & ~$past(ins_mask)) == ($past(dst_word) & ~$past(ins_mask))));
  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (result == '0 && !res_valid && !flag_n && !flag_z && !flag_c));
endmodule

// File: tb/bitfield_insert_inv_tb.sv
module bitfield_insert_inv_tb_top;
  logic clk = 0, rst = 1, in_valid = 0, c_in = 0;
  logic [15:0] src_word = 0, ctl_word = 0, dst_word = 0;
  logic [15:0] result;
  logic flag_n, flag_z, flag_v, flag_c, res_valid;
  int vectors = 0, miscompares = 0;

  always #10 clk = ~clk;

  bitfield_insert_inv dut_i (.clk, .rst, .in_valid, .src_word, .ctl_word,
    .dst_word, .c_in, .result, .flag_n, .flag_z, .flag_v, .flag_c, .res_valid);

  function automatic logic [15:0] model(input logic [15:0] s, c, d);
    logic [15:0] r = d;
    int len = int'(c[7:4]) + 1;
    int p = int'(c[3:0]);
    for (int i = 0; i < len; i++)
      if (p + i <= 15) r[p+i] = ~s[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] s, c, d, input logic ci, input string req);
    logic [15:0] e;
    src_word = s; ctl_word = c; dst_word = d; c_in = ci; in_valid = 1;
    @(posedge clk); #1;
    in_valid = 0;
    e = model(s, c, d);
    chk(req, result, e);
    chk("R5 n", flag_n, e[15]);
    chk("R5 z", flag_z, e == 0);
    chk("R6 v", flag_v, 0);
    chk("R6 c", flag_c, ci);
    chk("R7 valid", res_valid, 1);
  endtask

  initial begin
    #200000000;
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd1234));
    repeat (2) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 result", result, 0);
    chk("R9 valid", res_valid, 0);
    chk("R9 flags", {flag_n, flag_z, flag_v, flag_c}, 0);
    rst = 0;
    @(negedge clk);
    // R1/R2: width 4 offset 2
    apply(16'h0005, 16'h0032, 16'h0000, 0, "R2 basic");
    // R3: keep the outside bits
    apply(16'hFFFF, 16'h0034, 16'hFFFF, 1, "R3 keep");
    // R4: clipped at bit 15, field width 16 at offset 15
    apply(16'h0000, 16'h00FF, 16'h1234, 0, "R4 clip");
    // R4/R5: clipped field that yields a zero result
    apply(16'hFFFF, 16'h00FC, 16'h0000, 1, "R4 clip zero");
    // source of zeros sets the range
    apply(16'h0000, 16'h0070, 16'h0000, 0, "R2 set range");
    // full width at offset 0
    apply(16'h5A5A, 16'h00F0, 16'h0000, 0, "R1 full");
    // R8: upper control bits ignored
    apply(16'h0003, 16'hAB21, 16'h8001, 1, "R8 upper ctl");
    // R7: idle cycle holds the result and drops valid
    held = result;
    @(posedge clk); #1;
    chk("R7 idle valid", res_valid, 0);
    chk("R7 idle hold", result, held);
    // R9: reset mid-run clears the outputs
    rst = 1; @(posedge clk); #1;
    chk("R9 mid reset", {result, flag_n, flag_z, flag_c, res_valid}, 0);
    rst = 0;
    for (int w = 0; w < 16; w++)
      for (int o = 0; o < 16; o++)
        apply(16'($urandom), {8'($urandom), 4'(w), 4'(o)}, 16'($urandom), 1'($urandom), "R2 sweep");
    repeat (500)
      apply(16'($urandom), 16'($urandom), 16'($urandom), 1'($urandom), "R4 random");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule